// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block gathers the interrupt causes of one UART channel, keeps each cause in its own pending flag, masks the flags with per-source enables and reports the most urgent enabled cause. It drives a 6-bit identification code and an active-high interrupt request.

Each cause is cleared by the bus action that deals with it. Some causes are cleared by reading the identification code itself. In that case only the cause that the read reports is removed.

The receive FIFO, the serial shifter and the bus decoder are outside this block. They supply one-cycle event pulses, the aggregate receive-error level, the two flow-control pins and one-cycle access strobes. The code is combinational from the latched flags, so the bus can sample it in the same cycle as the read strobe.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, or whenever no enabled cause is pending, `iir_code` is 000001 and `irq` is 0. Events that arrive while reset is held are not recorded.
- R2: When causes are pending, the highest enabled one is reported, in this order from highest to lowest, with bit 0 of the code always 0:
  - line status: 000110
  - receive time-out: 001100
  - receive data: 000100
  - transmit empty: 000010
  - modem: 000000
  - flow character: 010000
  - pin change: 100000
- R3: The receive time-out cause outranks the receive data cause. A pulse on `rhr_rd` clears both of them.
- R4: The line-status cause is pending while `lsr_err` is high, or after an `ovr_evt` pulse. The overrun part is cleared only by `lsr_rd`; a `rhr_rd` leaves it pending.
- R5: The transmit-empty cause is cleared by `thr_wr`. It is also cleared by `iir_rd` in a cycle when it is the reported cause. A `thre_evt` in the same cycle as a clear keeps it pending.
- R6: The modem cause is cleared by `msr_rd`.
- R7: A flow-character cause set by `xoff_evt` is cleared only by `xon_evt`; `iir_rd` leaves it pending. A flow-character cause set by `spec_evt` is cleared by `iir_rd` while priority 5 is reported.
- R8: A low-to-high transition of `cts_n` or `rts_n` raises the pin-change cause, and a high-to-low transition does not. The cause is cleared by `iir_rd` while it is reported.
- R9: Bit i of `ier` enables cause i, in the priority order of R2 (bit 0 is line status, bit 6 is pin change). A disabled cause neither drives `irq` nor hides a lower enabled cause. It stays latched and appears once its bit is set. With `ier` all zero, `irq` is 0.
- R10: An `iir_rd` clears nothing but the cause it reports. An `iir_rd` while nothing is reported clears nothing.
- R11: A pulse or strobe sampled at a clock edge is reflected in `iir_code` and `irq` right after that edge. `lsr_err` acts combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier | input | 7 | Per-cause enables, bit i = cause i |
| lsr_err | input | 1 | Level: an erroneous character remains in the receive FIFO |
| ovr_evt | input | 1 | Pulse: receive overrun |
| rxto_evt | input | 1 | Pulse: receive time-out |
| rxdat_evt | input | 1 | Pulse: receive data reached threshold |
| thre_evt | input | 1 | Pulse: transmit holding became empty |
| modem_evt | input | 1 | Pulse: modem status changed |
| xoff_evt | input | 1 | Pulse: Xoff character detected |
| xon_evt | input | 1 | Pulse: Xon character detected |
| spec_evt | input | 1 | Pulse: special character detected |
| cts_n | input | 1 | Clear-to-send pin, active low |
| rts_n | input | 1 | Request-to-send pin, active low |
| iir_rd | input | 1 | Strobe: identification code read |
| lsr_rd | input | 1 | Strobe: line status read |
| rhr_rd | input | 1 | Strobe: receive holding read |
| thr_wr | input | 1 | Strobe: transmit holding write |
| msr_rd | input | 1 | Strobe: modem status read |
| irq | output | 1 | Interrupt request, active high |
| iir_code | output | 6 | Identification code of the reported cause |

## Verification
A flag stuck set shows up within one cycle as a code that does not return to 000001 after its clearing strobe. A flag stuck clear shows up as a missing code right after its event pulse. A wrong priority order or a wrong mask shows in the first cycle in which two causes are pending together. A wrong choice of which flag an identification read clears shows on the next cycle, as a lower cause that vanished or a reported one that stayed. A pin-edge detector of the wrong polarity raises 100000 on the falling transition instead of the rising one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int SRC_N  = 7;
   localparam int IDX_W  = $clog2(SRC_N);
   localparam int CODE_W = 6;

   typedef enum logic [IDX_W-1:0] {
      SRC_LINE  = 3'd0,
      SRC_RXTO  = 3'd1,
      SRC_RXDAT = 3'd2,
      SRC_THRE  = 3'd3,
      SRC_MODEM = 3'd4,
      SRC_FLOW  = 3'd5,
      SRC_PIN   = 3'd6
   } src_e;

   localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;

   function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx);
      case (idx)
         SRC_LINE:  src_code = 6'b000110;
         SRC_RXTO:  src_code = 6'b001100;
         SRC_RXDAT: src_code = 6'b000100;
         SRC_THRE:  src_code = 6'b000010;
         SRC_MODEM: src_code = 6'b000000;
         SRC_FLOW:  src_code = 6'b010000;
         SRC_PIN:   src_code = 6'b100000;
         default:   src_code = CODE_NONE;
      endcase
   endfunction
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("uart_irq_flag: W must be positive");
   end

   // a set in the same cycle as a clear wins, so no event is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end
endmodule

// File: rtl/uart_irq_pinedge.sv
module uart_irq_pinedge #(
   parameter int PINS        = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] pins_n,
   output logic            rise
);
   logic [PINS-1:0] cur;
   logic [PINS-1:0] prev;

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("uart_irq_pinedge: SYNC_STAGES must be 0..4");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign cur = pins_n;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0][PINS-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else begin
            chain[0] <= pins_n;
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign cur = chain[SYNC_STAGES-1];
   end

   // idle level is high (inactive), so reset does not fake an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= cur;
   end

   assign rise = |(cur & ~prev);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int N = SRC_N
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] sel
);
   if (N > (1 << IDX_W)) begin : g_bad_n
      $error("uart_irq_prio: N exceeds index width");
   end

   // lowest index is the highest priority
   always_comb begin
      sel = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) sel = IDX_W'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_N-1:0]  ier,
   input  logic              lsr_err,
   input  logic              ovr_evt,
   input  logic              rxto_evt,
   input  logic              rxdat_evt,
   input  logic              thre_evt,
   input  logic              modem_evt,
   input  logic              xoff_evt,
   input  logic              xon_evt,
   input  logic              spec_evt,
   input  logic              cts_n,
   input  logic              rts_n,
   input  logic              iir_rd,
   input  logic              lsr_rd,
   input  logic              rhr_rd,
   input  logic              thr_wr,
   input  logic              msr_rd,
   output logic              irq,
   output logic [CODE_W-1:0] iir_code
);
   localparam int FLAG_N = SRC_N + 1;
   localparam int F_OVR = 0, F_RXTO = 1, F_RXD = 2, F_THRE = 3,
                  F_MOD = 4, F_XOFF = 5, F_SPC = 6, F_PIN = 7;

   if (CODE_W != 6) begin : g_bad_code
      $error("uart_irq_ident: identification code must be 6 bits");
   end

   logic [FLAG_N-1:0] fset, fclr, flag;
   logic [SRC_N-1:0]  pend, masked;
   logic              pin_rise, any;
   logic [IDX_W-1:0]  sel;
   logic              rd_hit_thre, rd_hit_flow, rd_hit_pin;

   uart_irq_pinedge #(.PINS(2), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pins_n({rts_n, cts_n}), .rise(pin_rise)
   );

   // identification read clears only the cause it reports in this cycle
   assign rd_hit_thre = iir_rd && any && (sel == SRC_THRE);
   assign rd_hit_flow = iir_rd && any && (sel == SRC_FLOW);
   assign rd_hit_pin  = iir_rd && any && (sel == SRC_PIN);

   always_comb begin
      fset = '0;
      fset[F_OVR]  = ovr_evt;
      fset[F_RXTO] = rxto_evt;
      fset[F_RXD]  = rxdat_evt;
      fset[F_THRE] = thre_evt;
      fset[F_MOD]  = modem_evt;
      fset[F_XOFF] = xoff_evt;
      fset[F_SPC]  = spec_evt;
      fset[F_PIN]  = pin_rise;

      fclr = '0;
      fclr[F_OVR]  = lsr_rd;
      fclr[F_RXTO] = rhr_rd;
      fclr[F_RXD]  = rhr_rd;
      fclr[F_THRE] = thr_wr | rd_hit_thre;
      fclr[F_MOD]  = msr_rd;
      fclr[F_XOFF] = xon_evt;
      fclr[F_SPC]  = rd_hit_flow;
      fclr[F_PIN]  = rd_hit_pin;
   end

   uart_irq_flag #(.W(FLAG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(fset), .clr(fclr), .q(flag)
   );

   always_comb begin
      pend = '0;
      pend[SRC_LINE]  = lsr_err | flag[F_OVR];
      pend[SRC_RXTO]  = flag[F_RXTO];
      pend[SRC_RXDAT] = flag[F_RXD];
      pend[SRC_THRE]  = flag[F_THRE];
      pend[SRC_MODEM] = flag[F_MOD];
      pend[SRC_FLOW]  = flag[F_XOFF] | flag[F_SPC];
      pend[SRC_PIN]   = flag[F_PIN];
   end

   assign masked = pend & ier;

   uart_irq_prio #(.N(SRC_N)) u_prio (
      .req(masked), .any(any), .sel(sel)
   );

   assign irq      = any;
   assign iir_code = any ? src_code(sel) : CODE_NONE;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [6:0] ier,
   input logic       lsr_err,
   input logic       rxto_evt,
   input logic       rxdat_evt,
   input logic       thre_evt,
   input logic       modem_evt,
   input logic       rhr_rd,
   input logic       thr_wr,
   input logic       msr_rd,
   input logic       irq,
   input logic [5:0] iir_code
);
   assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> iir_code == 6'b000001);

   assert_active_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !iir_code[0]);

   assert_rhr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rhr_rd && !rxto_evt && !rxdat_evt && !lsr_err) |=>
         (iir_code != 6'b001100 && iir_code != 6'b000100));

   assert_line_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_err && ier[0]) |-> iir_code == 6'b000110);

   assert_thr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr && !thre_evt) |=> iir_code != 6'b000010);

   assert_msr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd && !modem_evt) |=> iir_code != 6'b000000);

   assert_all_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ier == 7'd0) |-> !irq);
endmodule

bind uart_irq_ident uart_irq_ident_chk chk (.*);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
   logic clk = 0, rst_n = 0;
   logic [6:0] ier = '0;
   logic lsr_err = 0, ovr_evt = 0, rxto_evt = 0, rxdat_evt = 0, thre_evt = 0;
   logic modem_evt = 0, xoff_evt = 0, xon_evt = 0, spec_evt = 0;
   logic cts_n = 1, rts_n = 1;
   logic iir_rd = 0, lsr_rd = 0, rhr_rd = 0, thr_wr = 0, msr_rd = 0;
   logic irq;
   logic [5:0] iir_code;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   uart_irq_ident uut (.*);

   // ev: ovr rxto rxdat thre modem xoff spec ; st: iir lsr rhr thr msr
   typedef struct packed {
      logic [6:0] ier;
      logic       lerr;
      logic [6:0] ev;
      logic       xon;
      logic [4:0] st;
      logic [5:0] code;
      logic       irq;
      logic [3:0] req;
   } vec_t;

   localparam logic [6:0] A = 7'h7f;
   localparam logic [6:0] E0 = 7'b0000000, EOVR = 7'b1000000, ETO = 7'b0100000,
      ERD = 7'b0010000, ETH = 7'b0001000, EMD = 7'b0000100, EXF = 7'b0000010,
      ESP = 7'b0000001;
   localparam logic [4:0] S0 = 5'b00000, SIIR = 5'b10000, SLSR = 5'b01000,
      SRHR = 5'b00100, STHR = 5'b00010, SMSR = 5'b00001;
   localparam int NV = 31;

   localparam vec_t VECS [NV] = '{
      '{A, 1'b0, ETH,     1'b0, S0,   6'b000010, 1'b1, 4'd11}, // R11 R2
      '{A, 1'b0, EMD,     1'b0, S0,   6'b000010, 1'b1, 4'd2 }, // R2 thre over modem
      '{A, 1'b0, E0,      1'b0, SIIR, 6'b000000, 1'b1, 4'd5 }, // R5 R10
      '{A, 1'b0, E0,      1'b0, SMSR, 6'b000001, 1'b0, 4'd6 }, // R6
      '{A, 1'b0, ERD|ETH, 1'b0, S0,   6'b000100, 1'b1, 4'd2 }, // R2
      '{A, 1'b0, ETO,     1'b0, S0,   6'b001100, 1'b1, 4'd3 }, // R3 timeout first
      '{A, 1'b0, E0,      1'b0, SRHR, 6'b000010, 1'b1, 4'd3 }, // R3 both cleared
      '{A, 1'b0, E0,      1'b0, STHR, 6'b000001, 1'b0, 4'd5 }, // R5 write clears
      '{A, 1'b1, E0,      1'b0, S0,   6'b000110, 1'b1, 4'd4 }, // R4 level
      '{A, 1'b0, E0,      1'b0, S0,   6'b000001, 1'b0, 4'd4 }, // R4 level gone
      '{A, 1'b0, EOVR,    1'b0, S0,   6'b000110, 1'b1, 4'd4 }, // R4 overrun
      '{A, 1'b0, E0,      1'b0, SRHR, 6'b000110, 1'b1, 4'd4 }, // R4 rhr ignored
      '{A, 1'b0, E0,      1'b0, SLSR, 6'b000001, 1'b0, 4'd4 }, // R4 lsr clears
      '{A, 1'b0, EXF,     1'b0, S0,   6'b010000, 1'b1, 4'd7 }, // R7
      '{A, 1'b0, E0,      1'b0, SIIR, 6'b010000, 1'b1, 4'd7 }, // R7 read ignored
      '{A, 1'b0, E0,      1'b1, S0,   6'b000001, 1'b0, 4'd7 }, // R7 xon clears
      '{A, 1'b0, ESP,     1'b0, S0,   6'b010000, 1'b1, 4'd7 }, // R7 special
      '{A, 1'b0, E0,      1'b0, SIIR, 6'b000001, 1'b0, 4'd7 }, // R7 read clears
      '{7'h00, 1'b0, EMD, 1'b0, S0,   6'b000001, 1'b0, 4'd9 }, // R9 masked
      '{7'h00, 1'b0, E0,  1'b0, SIIR, 6'b000001, 1'b0, 4'd10}, // R10 nothing cleared
      '{7'h10, 1'b0, E0,  1'b0, S0,   6'b000000, 1'b1, 4'd9 }, // R9 retained
      '{7'h10, 1'b0, E0,  1'b0, SMSR, 6'b000001, 1'b0, 4'd6 }, // R6
      '{7'h00, 1'b0, ETH, 1'b0, SIIR, 6'b000001, 1'b0, 4'd10}, // R10 masked read
      '{7'h08, 1'b0, E0,  1'b0, S0,   6'b000010, 1'b1, 4'd10}, // R10 thre kept
      '{A, 1'b0, ETH,     1'b0, SIIR, 6'b000010, 1'b1, 4'd5 }, // R5 set wins
      '{A, 1'b0, E0,      1'b0, STHR, 6'b000001, 1'b0, 4'd5 }, // R5
      '{A, 1'b1, ETH,     1'b0, SIIR, 6'b000110, 1'b1, 4'd10}, // R10 line reported
      '{A, 1'b0, E0,      1'b0, S0,   6'b000010, 1'b1, 4'd10}, // R10 thre survived
      '{A, 1'b0, E0,      1'b0, STHR, 6'b000001, 1'b0, 4'd5 }, // R5
      '{7'h7e, 1'b1, EMD, 1'b0, S0,   6'b000000, 1'b1, 4'd9 }, // R9 masked line
      '{A, 1'b0, E0,      1'b0, SMSR, 6'b000001, 1'b0, 4'd6 }  // R6
   };

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic check(input string tag, input logic [5:0] ecode, input logic eirq);
      checks++;
      if (iir_code !== ecode || irq !== eirq) begin
         errors++;
         $display("FAIL %s code=%b irq=%b expected code=%b irq=%b",
                  tag, iir_code, irq, ecode, eirq);
      end
   endtask

   task automatic drive(input vec_t v);
      ier = v.ier; lsr_err = v.lerr;
      {ovr_evt, rxto_evt, rxdat_evt, thre_evt, modem_evt, xoff_evt, spec_evt} = v.ev;
      xon_evt = v.xon;
      {iir_rd, lsr_rd, rhr_rd, thr_wr, msr_rd} = v.st;
   endtask

   task automatic step_idle();
      @(negedge clk);
      drive('{A, 1'b0, E0, 1'b0, S0, 6'b0, 1'b0, 4'd0});
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: events during reset are not recorded
      ier = A; thre_evt = 1; modem_evt = 1;
      repeat (3) @(posedge clk);
      #1 check("R1 in reset", 6'b000001, 1'b0);
      @(negedge clk); thre_evt = 0; modem_evt = 0; rst_n = 1;
      @(posedge clk); #1 check("R1 after reset", 6'b000001, 1'b0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i]);
         @(posedge clk); #1;
         check($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].code, VECS[i].irq);
      end

      // R8: falling pin gives nothing, rising pin raises
      @(negedge clk); drive('{A, 1'b0, E0, 1'b0, S0, 6'b0, 1'b0, 4'd0}); cts_n = 0;
      @(posedge clk); #1 check("R8 cts fall", 6'b000001, 1'b0);
      @(negedge clk); cts_n = 1;
      @(posedge clk); #1 check("R8 cts rise", 6'b100000, 1'b1);
      @(negedge clk); iir_rd = 1;
      @(posedge clk); #1 check("R8 read clears", 6'b000001, 1'b0);
      @(negedge clk); iir_rd = 0; rts_n = 0;
      @(posedge clk); #1 check("R8 rts fall", 6'b000001, 1'b0);
      @(negedge clk); rts_n = 1;
      @(posedge clk); #1 check("R8 rts rise", 6'b100000, 1'b1);
      // R2: flow character over pin change
      @(negedge clk); xoff_evt = 1;
      @(posedge clk); #1 check("R2 xoff over pin", 6'b010000, 1'b1);
      @(negedge clk); xoff_evt = 0; xon_evt = 1;
      @(posedge clk); #1 check("R7 xon leaves pin", 6'b100000, 1'b1);
      @(negedge clk); xon_evt = 0; iir_rd = 1;
      @(posedge clk); #1 check("R8 second read", 6'b000001, 1'b0);
      step_idle();
      check("R1 idle", 6'b000001, 1'b0);

      // R1: reset in mid-run drops a pending cause
      @(negedge clk); thre_evt = 1;
      @(posedge clk); #1 check("R5 pending", 6'b000010, 1'b1);
      @(negedge clk); thre_evt = 0; rst_n = 0;
      @(posedge clk); #1 check("R1 reset mid-run", 6'b000001, 1'b0);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #1 check("R1 released", 6'b000001, 1'b0);

      finish_run();
   end
endmodule